// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one asynchronous interrupt request pin. It turns qualifying pin activity into a sticky status flag and, when enabled, a level interrupt request toward the processor. Software configures it with a single write-strobed control word. That word enables the pin, picks the active polarity, chooses between edge-only detection and edge-plus-level detection, gates the interrupt request, and carries a write-one acknowledge that clears the flag.

The pin first passes through a multi-flop synchronizer on the system clock. A history register then detects transitions into the active level. In edge-plus-level mode the flag is also reasserted on every cycle the pin rests at the active level. The block has three further outputs:
- the synchronized pin level, so software can branch on the pin state;
- a pull-direction select that follows the polarity choice;
- a purely combinational wake request that works while the system clock is stopped.

Top module: `extint_pin_ctrl`

## Requirements
- R1: After the synchronous reset, flag_o, irq_o, pin_lvl_o and pull_dn_o are all 0.
- R2: While the pin-enable bit (ctl_wdata_i bit 0) is 0, the flag is never set, pin_lvl_o reads 0 and wake_o stays 0.
- R3: With polarity bit (bit 1) at 0 and mode bit (bit 2) at 0, a falling edge sets the flag. A pin that stays low after an acknowledge does not set the flag again.
- R4: With polarity bit 1 set, a rising edge sets the flag and a falling edge does not.
- R5: With mode bit 2 set, the flag is reasserted on every cycle the synchronized pin sits at the active level, so an acknowledge cannot clear it. Once the pin is inactive, an acknowledge clears it.
- R6: irq_o is 1 only while the flag is set and the interrupt-enable bit (bit 3) is 1. With bit 3 at 0, the flag still sets.
- R7: A write with the acknowledge bit (bit 4) set clears the flag on the write's clock edge. A later event sets it again.
- R8: When an acknowledge and a detected event land on the same clock edge, the flag stays set.
- R9: A write that changes the polarity or mode bit does not by itself produce an edge event.
- R10: pull_dn_o equals the stored polarity bit (1 selects pulldown for rising/high detection), effective on the write edge.
- R11: A pin change shows on pin_lvl_o and, for a qualifying event, on flag_o after the third rising clock edge, and not earlier.
- R12: With stop_i high and the pin enabled, wake_o follows the raw pin's active level combinationally, with no clock edge needed. With stop_i low, wake_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Raw asynchronous interrupt pin |
| stop_i | input | 1 | High while system clocks are stopped |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | CTL_W | Control word: bit0 enable, bit1 rising/high polarity, bit2 edge-plus-level mode, bit3 interrupt enable, bit4 acknowledge |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request to the processor |
| pin_lvl_o | output | 1 | Synchronized pin level, 0 while disabled |
| pull_dn_o | output | 1 | 1 selects pulldown, 0 selects pullup |
| wake_o | output | 1 | Asynchronous stop-mode wake request |

## Verification
Each result has its own latency:
- a pin change reaches pin_lvl_o and flag_o on the third rising edge after it is driven;
- a control write (including acknowledge, interrupt enable and pull select) takes effect on the edge that samples it;
- in edge-plus-level mode, a mode change with the pin already active sets the flag on the second edge.

The driver stamps every expected value with the cycle number at which it falls due. The monitor compares only at the falling edge of that cycle, so a result that arrives one cycle early or late is reported. The wake path is checked with the clock halted, a moment after each pin or stop change.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int CTL_W = 5;

  typedef struct packed {
    logic ack;
    logic irq_en;
    logic lvl_mode;
    logic pol_rise;
    logic pin_en;
  } ctl_t;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b0;
        else     stg[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/extint_detect.sv
module extint_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic en_i,
  input  logic pol_rise_i,
  input  logic lvl_mode_i,
  input  logic rearm_i,
  output logic evt_o,
  output logic active_o
);
  logic act;
  logic hist_q;

  assign act      = pol_rise_i ? lvl_i : ~lvl_i;
  assign active_o = act;

  // history parked at "already active" while disabled or on a config change
  always_ff @(posedge clk) begin
    if (rst)                  hist_q <= 1'b1;
    else if (!en_i || rearm_i) hist_q <= 1'b1;
    else                      hist_q <= act;
  end

  assign evt_o = en_i & ((act & ~hist_q) | (lvl_mode_i & act));

  // R9: a config change yields no edge event on the following cycle
  p_rearm_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    rearm_i |=> (!evt_o || lvl_mode_i));
endmodule

// File: rtl/extint_wake.sv
module extint_wake (
  input  logic pin_i,
  input  logic stop_i,
  input  logic en_i,
  input  logic pol_rise_i,
  output logic wake_o
);
  logic raw_act;

  assign raw_act = pol_rise_i ? pin_i : ~pin_i;
  assign wake_o  = stop_i & en_i & raw_act;
endmodule

// File: rtl/extint_pin_ctrl.sv
module extint_pin_ctrl
  import extint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_i,
  input  logic             stop_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic             flag_o,
  output logic             irq_o,
  output logic             pin_lvl_o,
  output logic             pull_dn_o,
  output logic             wake_o
);
  ctl_t wr;
  ctl_t cfg_q, cfg_n;
  logic ack_wr, rearm;
  logic sync_lvl, evt, active;
  logic flag_q, flag_n, irq_q, lvl_q;

  assign wr     = ctl_t'(ctl_wdata_i);
  assign ack_wr = ctl_we_i & wr.ack;
  assign rearm  = ctl_we_i & ((wr.pol_rise != cfg_q.pol_rise) |
                              (wr.lvl_mode != cfg_q.lvl_mode));

  always_comb begin
    cfg_n = cfg_q;
    if (ctl_we_i) begin
      cfg_n     = wr;
      cfg_n.ack = 1'b0;
    end
  end

  extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (sync_lvl)
  );

  extint_detect u_det (
    .clk        (clk),
    .rst        (rst),
    .lvl_i      (sync_lvl),
    .en_i       (cfg_q.pin_en),
    .pol_rise_i (cfg_q.pol_rise),
    .lvl_mode_i (cfg_q.lvl_mode),
    .rearm_i    (rearm),
    .evt_o      (evt),
    .active_o   (active)
  );

  extint_wake u_wake (
    .pin_i      (pin_i),
    .stop_i     (stop_i),
    .en_i       (cfg_q.pin_en),
    .pol_rise_i (cfg_q.pol_rise),
    .wake_o     (wake_o)
  );

  // event has priority over acknowledge
  always_comb begin
    flag_n = flag_q;
    if (evt)         flag_n = 1'b1;
    else if (ack_wr) flag_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      flag_q <= flag_n;
      irq_q  <= flag_n & cfg_n.irq_en;
      lvl_q  <= cfg_n.pin_en & sync_lvl;
    end
  end

  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign pin_lvl_o = lvl_q;
  assign pull_dn_o = cfg_q.pol_rise;

  // R2: flag can only rise while the pin was enabled
  p_off_no_set_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(cfg_q.pin_en));

  // R7: acknowledge without a competing event clears the flag
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && !evt) |=> !flag_q);

  // R8: event wins over a same-edge acknowledge
  p_evt_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && evt) |=> flag_q);

  // R5: active level in level mode keeps the flag set
  p_level_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.pin_en && cfg_q.lvl_mode && active) |=> flag_q);
endmodule

// File: tb/extint_pin_ctrl_tb_top.sv
module extint_pin_ctrl_tb_top;
  localparam int FLD_FLAG = 0;
  localparam int FLD_IRQ  = 1;
  localparam int FLD_LVL  = 2;
  localparam int FLD_PULL = 3;

  typedef struct {
    int    due;
    int    fld;
    logic  val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       run = 1'b1;
  logic       rst;
  logic       pin;
  logic       stop;
  logic       we;
  logic [4:0] wd;
  logic       flag, irq, lvl, pull, wake;

  int   cyc    = 0;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t sb[$];

  extint_pin_ctrl dut_i (
    .clk         (clk),
    .rst         (rst),
    .pin_i       (pin),
    .stop_i      (stop),
    .ctl_we_i    (we),
    .ctl_wdata_i (wd),
    .flag_o      (flag),
    .irq_o       (irq),
    .pin_lvl_o   (lvl),
    .pull_dn_o   (pull),
    .wake_o      (wake)
  );

  always #2 if (run) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic push_exp(int fld, logic v, int dly, string tag);
    exp_t e;
    e.due = cyc + dly;
    e.fld = fld;
    e.val = v;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic nclk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] d);
    we = 1'b1;
    wd = d;
    nclk(1);
    we = 1'b0;
    wd = '0;
  endtask

  // monitor: compare due scoreboard entries
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        case (sb[i].fld)
          FLD_FLAG: check(sb[i].tag, flag, sb[i].val);
          FLD_IRQ:  check(sb[i].tag, irq,  sb[i].val);
          FLD_LVL:  check(sb[i].tag, lvl,  sb[i].val);
          default:  check(sb[i].tag, pull, sb[i].val);
        endcase
        sb.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; pin = 1'b1; stop = 1'b0; we = 1'b0; wd = '0;
    nclk(3);
    rst = 1'b0;
    push_exp(FLD_FLAG, 1'b0, 1, "R1");
    push_exp(FLD_IRQ,  1'b0, 1, "R1");
    push_exp(FLD_LVL,  1'b0, 1, "R1");
    push_exp(FLD_PULL, 1'b0, 1, "R1");
    nclk(2);

    // R2: disabled pin ignores a falling edge
    pin = 1'b0;
    push_exp(FLD_FLAG, 1'b0, 3, "R2");
    push_exp(FLD_LVL,  1'b0, 3, "R2");
    nclk(4);
    pin = 1'b1;
    nclk(3);

    // enable, falling, edge-only, no irq
    push_exp(FLD_PULL, 1'b0, 1, "R10");
    push_exp(FLD_LVL,  1'b1, 1, "R11");
    wr(5'b00001);
    nclk(3);

    // R3 falling edge, R11 latency, R6 irq gated off
    pin = 1'b0;
    push_exp(FLD_FLAG, 1'b0, 2, "R11");
    push_exp(FLD_FLAG, 1'b1, 3, "R3");
    push_exp(FLD_LVL,  1'b0, 3, "R11");
    push_exp(FLD_IRQ,  1'b0, 3, "R6");
    nclk(4);
    push_exp(FLD_FLAG, 1'b0, 1, "R7");
    wr(5'b10001);
    push_exp(FLD_FLAG, 1'b0, 4, "R3");
    nclk(5);

    // R6 irq enabled
    push_exp(FLD_IRQ, 1'b0, 1, "R6");
    wr(5'b01001);
    pin = 1'b1;
    nclk(3);
    pin = 1'b0;
    push_exp(FLD_FLAG, 1'b1, 3, "R6");
    push_exp(FLD_IRQ,  1'b1, 3, "R6");
    nclk(4);
    push_exp(FLD_FLAG, 1'b0, 1, "R7");
    push_exp(FLD_IRQ,  1'b0, 1, "R7");
    wr(5'b11001);
    pin = 1'b1;
    nclk(3);

    // R7 re-set after acknowledge
    pin = 1'b0;
    push_exp(FLD_FLAG, 1'b1, 3, "R7");
    nclk(4);
    pin = 1'b1;
    nclk(3);

    // R8 acknowledge and event on the same edge
    pin = 1'b0;
    nclk(2);
    push_exp(FLD_FLAG, 1'b1, 1, "R8");
    wr(5'b11001);
    nclk(1);
    push_exp(FLD_FLAG, 1'b0, 1, "R7");
    wr(5'b11001);
    nclk(2);

    // R9 polarity change without spurious event
    pin = 1'b1;
    nclk(3);
    push_exp(FLD_PULL, 1'b1, 1, "R10");
    push_exp(FLD_FLAG, 1'b0, 1, "R9");
    push_exp(FLD_FLAG, 1'b0, 2, "R9");
    push_exp(FLD_FLAG, 1'b0, 3, "R9");
    wr(5'b01011);
    nclk(3);

    // R4 rising polarity
    pin = 1'b0;
    push_exp(FLD_FLAG, 1'b0, 3, "R4");
    nclk(4);
    pin = 1'b1;
    push_exp(FLD_FLAG, 1'b1, 3, "R4");
    push_exp(FLD_IRQ,  1'b1, 3, "R4");
    nclk(4);
    push_exp(FLD_FLAG, 1'b0, 1, "R7");
    wr(5'b11011);
    nclk(2);

    // R5 edge-plus-level mode with pin already active
    push_exp(FLD_FLAG, 1'b1, 2, "R5");
    wr(5'b01111);
    nclk(3);
    push_exp(FLD_FLAG, 1'b1, 1, "R5");
    push_exp(FLD_FLAG, 1'b1, 2, "R5");
    wr(5'b11111);
    nclk(2);
    pin = 1'b0;
    nclk(3);
    push_exp(FLD_FLAG, 1'b0, 1, "R5");
    wr(5'b11111);
    push_exp(FLD_FLAG, 1'b0, 3, "R5");
    nclk(4);

    // R12 wake with the clock halted
    run = 1'b0;
    stop = 1'b1;
    #1 check("R12", wake, 1'b0);
    pin = 1'b1;
    #1 check("R12", wake, 1'b1);
    pin = 1'b0;
    #1 check("R12", wake, 1'b0);
    pin = 1'b1;
    stop = 1'b0;
    #1 check("R12", wake, 1'b0);
    pin = 1'b0;
    run = 1'b1;
    nclk(4);
    wr(5'b11111);
    nclk(2);

    // R2: disabled pin gives no wake, no flag, level 0
    push_exp(FLD_LVL, 1'b0, 1, "R2");
    wr(5'b00010);
    stop = 1'b1;
    pin = 1'b1;
    #1 check("R2", wake, 1'b0);
    stop = 1'b0;
    push_exp(FLD_FLAG, 1'b0, 3, "R2");
    push_exp(FLD_LVL,  1'b0, 3, "R2");
    nclk(4);
    pin = 1'b0;
    nclk(3);
    finish_run();
  end
endmodule